// File: doc/BRIEF.md
# Trigger-Latency Pipeline with Capture Buffer Bank

The block holds a stream of multi-channel sample words in a circular two-port memory so that each word waits a fixed, programmable number of ticks while a first-level trigger decision is made. One port writes the incoming word on every tick. The other port reads, on the same tick, the word stored a configurable number of addresses behind the write pointer. A crossing marker restarts the write address at zero.

A first-level accept copies a run of these delayed words into one of four capture buffers, selected by a 2-bit field. Each buffer has its own write counter and remembers the length of its latest capture. Captures into different buffers may overlap in time. A buffer can be overwritten by a later capture whether or not it was read, and its contents are never cleared.

A second-level accept starts a readout sweep. One shared read counter walks the chosen buffer from word 0 to its captured length. The words leave with a valid strobe, and the final word carries a last flag for the downstream hit finder. While a sweep runs, the block reports busy and ignores further second-level accepts.

Top module: `trig_latency_buf`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `busy_o`, `rd_valid_o` and `rd_last_o` are low.
- R2: Pipeline write address. A sample presented together with `xing_i` is stored at address 0. On every later tick the address advances by one and wraps at the pipeline depth (512 by default).
- R3: On every tick the pipeline reads address (write address − `lat_offset_i`) mod depth. It returns the content held before that tick's write, and the result is registered as the delayed word.
- R4: When `l1_accept_i` is sampled high on tick t, capture buffer `l1_sel_i` (values 0 to 3 name buffers 0 to 3) receives as word k the delayed word read on tick t+k.
- R5: The capture length is taken from `cap_len_i` on the accept tick. A value from 1 to 32 is used as given; 0, or any value above 32, means 32.
- R6: Each buffer has its own write counter. Captures into different buffers may overlap, and a buffer may fill while another is being read. A new accept to a buffer that is still capturing restarts it at word 0 with the new length.
- R7: A later capture overwrites a buffer whether or not it was read. A readout then returns the later capture.
- R8: When `l2_accept_i` is sampled high on tick t while `busy_o` is low, buffer `l2_sel_i` is read from word 0 to its last captured length − 1 (32 if it was never captured). Word k appears on `rd_data_o` with `rd_valid_o` high after the clock edge of tick t+2+k, and the words are contiguous.
- R9: `rd_last_o` is high with the final word of a sweep and low with every other word.
- R10: `busy_o` is high from the tick after an accepted second-level accept until the final word address has been issued. A second-level accept sampled while `busy_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample tick clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 40 | Parallel sample word, 10 bits per channel |
| xing_i | input | 1 | Crossing marker; restarts the write address at 0 |
| lat_offset_i | input | 9 | Read distance behind the write pointer (latency) |
| cap_len_i | input | 6 | Words to capture per first-level accept |
| l1_accept_i | input | 1 | First-level accept strobe |
| l1_sel_i | input | 2 | Capture buffer for the first-level accept |
| l2_accept_i | input | 1 | Second-level accept strobe |
| l2_sel_i | input | 2 | Buffer to read out on the second-level accept |
| rd_data_o | output | 40 | Readout word |
| rd_valid_o | output | 1 | Readout word valid |
| rd_last_o | output | 1 | Final word of the sweep |
| busy_o | output | 1 | Readout sweep in progress |

## Verification
The assertions rely on three properties of the inputs. The strobes are synchronous single-cycle pulses. No sweep reads a buffer while a capture into that same buffer is still running. The pipeline has been written through once before any data check uses its contents. The stimulus meets these conditions as follows. It runs 600 ticks after reset before the first capture. It waits for each capture to complete before reading that buffer. It reads a never-captured buffer only to count words, not to compare data. Overlap cases always pair different buffers, except for the deliberate restart case, which reads only after the restarted capture has ended.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Tag that travels with a read address through the readout pipeline
  typedef struct packed {
    logic vld;
    logic last;
  } rd_tag_t;

  // Clip a requested capture length: 0 or too large selects the full buffer
  function automatic int unsigned clip_len(input int unsigned req, input int unsigned full);
    if (req == 0 || req > full) return full;
    return req;
  endfunction

endpackage

// File: rtl/tlb_pipe_mem.sv
module tlb_pipe_mem #(
  parameter int W     = 40,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xing_i,
  input  logic [W-1:0]  din_i,
  input  logic [AW-1:0] offset_i,
  output logic [W-1:0]  dly_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_cnt;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [W-1:0]  dly_q;

  // Marker forces this tick's write to address 0
  always_comb begin
    wr_ptr = xing_i ? '0 : wr_cnt;
    rd_ptr = wr_ptr - offset_i;
  end

  always_ff @(posedge clk) begin
    if (rst) wr_cnt <= '0;
    else     wr_cnt <= wr_ptr + 1'b1;
  end

  // Two-port memory: write every tick, registered read of the old content
  always_ff @(posedge clk) begin
    mem[wr_ptr] <= din_i;
    dly_q       <= mem[rd_ptr];
  end

  assign dly_o = dly_q;

endmodule

// File: rtl/tlb_cap_buf.sv
module tlb_cap_buf #(
  parameter int W     = 40,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic [W-1:0]  din_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] len_o
);

  logic [W-1:0]  ram [DEPTH];
  logic          act_q;
  logic [AW-1:0] wc_q;
  logic [LW-1:0] len_q;
  logic          wc_end;
  logic [W-1:0]  rdata_q;

  assign wc_end = ({1'b0, wc_q} == (len_q - 1'b1));

  // Private write counter; a new start restarts the capture at word 0
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      wc_q  <= '0;
      len_q <= LW'(DEPTH);
    end else if (start_i) begin
      act_q <= 1'b1;
      wc_q  <= '0;
      len_q <= len_i;
    end else if (act_q) begin
      wc_q <= wc_q + 1'b1;
      if (wc_end) act_q <= 1'b0;
    end
  end

  // Storage is never cleared; read port is registered
  always_ff @(posedge clk) begin
    if (act_q) ram[wc_q] <= din_i;
    rdata_q <= ram[raddr_i];
  end

  assign rdata_o = rdata_q;
  assign len_o   = len_q;

endmodule

// File: rtl/tlb_readout.sv
module tlb_readout #(
  parameter int SW = 2,
  parameter int AW = 5,
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [SW-1:0]    sel_i,
  input  logic [LW-1:0]    len_i,
  output logic             busy_o,
  output logic [AW-1:0]    raddr_o,
  output tlb_pkg::rd_tag_t tag_o,
  output logic [SW-1:0]    sel_o
);

  logic             busy_q;
  logic [SW-1:0]    rsel_q;
  logic [AW-1:0]    rcnt_q;
  logic [LW-1:0]    rlen_q;
  logic             at_end;
  tlb_pkg::rd_tag_t tag_q;
  logic [SW-1:0]    sel1_q;

  assign at_end = ({1'b0, rcnt_q} == (rlen_q - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rsel_q <= '0;
      rcnt_q <= '0;
      rlen_q <= '0;
      tag_q  <= '0;
      sel1_q <= '0;
    end else begin
      tag_q <= '0;
      if (busy_q) begin
        // Issue one address per tick; tag and select follow it down the pipe
        tag_q.vld  <= 1'b1;
        tag_q.last <= at_end;
        sel1_q     <= rsel_q;
        rcnt_q     <= rcnt_q + 1'b1;
        if (at_end) busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        rsel_q <= sel_i;
        rcnt_q <= '0;
        rlen_q <= len_i;
      end
    end
  end

  assign busy_o  = busy_q;
  assign raddr_o = rcnt_q;
  assign tag_o   = tag_q;
  assign sel_o   = sel1_q;

endmodule

// File: rtl/trig_latency_buf.sv
module trig_latency_buf #(
  parameter int NCH        = 4,
  parameter int CHW        = 10,
  parameter int PIPE_DEPTH = 512,
  parameter int NBUF       = 4,
  parameter int BUF_DEPTH  = 32,
  localparam int W   = NCH * CHW,
  localparam int PAW = $clog2(PIPE_DEPTH),
  localparam int BAW = $clog2(BUF_DEPTH),
  localparam int LW  = BAW + 1,
  localparam int SW  = $clog2(NBUF)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   sample_i,
  input  logic           xing_i,
  input  logic [PAW-1:0] lat_offset_i,
  input  logic [LW-1:0]  cap_len_i,
  input  logic           l1_accept_i,
  input  logic [SW-1:0]  l1_sel_i,
  input  logic           l2_accept_i,
  input  logic [SW-1:0]  l2_sel_i,
  output logic [W-1:0]   rd_data_o,
  output logic           rd_valid_o,
  output logic           rd_last_o,
  output logic           busy_o
);

  logic [W-1:0]     dly_word;
  logic [LW-1:0]    eff_len;
  logic [W-1:0]     buf_q   [NBUF];
  logic [LW-1:0]    buf_len [NBUF];
  logic [BAW-1:0]   rd_addr;
  tlb_pkg::rd_tag_t rd_tag;
  logic [SW-1:0]    rd_sel1;

  tlb_pipe_mem #(.W(W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .xing_i  (xing_i),
    .din_i   (sample_i),
    .offset_i(lat_offset_i),
    .dly_o   (dly_word)
  );

  assign eff_len = LW'(tlb_pkg::clip_len(int'(cap_len_i), BUF_DEPTH));

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    tlb_cap_buf #(.W(W), .DEPTH(BUF_DEPTH)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .start_i(l1_accept_i && (l1_sel_i == SW'(b))),
      .len_i  (eff_len),
      .din_i  (dly_word),
      .raddr_i(rd_addr),
      .rdata_o(buf_q[b]),
      .len_o  (buf_len[b])
    );
  end

  tlb_readout #(.SW(SW), .AW(BAW)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .start_i(l2_accept_i),
    .sel_i  (l2_sel_i),
    .len_i  (buf_len[l2_sel_i]),
    .busy_o (busy_o),
    .raddr_o(rd_addr),
    .tag_o  (rd_tag),
    .sel_o  (rd_sel1)
  );

  // Output stage: pick the buffer that the tagged address was issued to
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      rd_last_o  <= 1'b0;
    end else begin
      rd_data_o  <= buf_q[rd_sel1];
      rd_valid_o <= rd_tag.vld;
      rd_last_o  <= rd_tag.vld && rd_tag.last;
    end
  end

endmodule

// File: rtl/trig_latency_buf_chk.sv
module trig_latency_buf_chk (
  input logic clk,
  input logic rst,
  input logic l2_accept_i,
  input logic busy_o,
  input logic rd_valid_o,
  input logic rd_last_o
);

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid_o && !busy_o && !rd_last_o));

  assert_burst_contiguous_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_last_o) |=> rd_valid_o);

  assert_last_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
    rd_last_o |-> rd_valid_o);

  assert_end_marks_last_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |=> rd_last_o);

  assert_accept_sets_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (l2_accept_i && !busy_o) |=> busy_o);

endmodule

bind trig_latency_buf trig_latency_buf_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .l2_accept_i(l2_accept_i),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .rd_last_o  (rd_last_o)
);

// File: tb/trig_latency_buf_bench.sv
module trig_latency_buf_bench;
  localparam int W  = 40;
  localparam int PD = 512;
  localparam int HN = 8192;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] sample_i;
  logic         xing_i;
  logic [8:0]   lat_offset_i;
  logic [5:0]   cap_len_i;
  logic         l1_accept_i;
  logic [1:0]   l1_sel_i;
  logic         l2_accept_i;
  logic [1:0]   l2_sel_i;
  logic [W-1:0] rd_data_o;
  logic         rd_valid_o;
  logic         rd_last_o;
  logic         busy_o;

  always #2.5 clk = ~clk;

  trig_latency_buf u_trig_latency_buf (
    .clk(clk), .rst(rst), .sample_i(sample_i), .xing_i(xing_i),
    .lat_offset_i(lat_offset_i), .cap_len_i(cap_len_i),
    .l1_accept_i(l1_accept_i), .l1_sel_i(l1_sel_i),
    .l2_accept_i(l2_accept_i), .l2_sel_i(l2_sel_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .rd_last_o(rd_last_o), .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements (R2, R3, R4, R5)
  logic [W-1:0] mdl  [PD];
  logic [W-1:0] hist [HN];
  int tick = 0;
  int cntm = 0;
  int acc_tick [4];
  int acc_len  [4];

  function automatic int eff(input int req);
    return (req == 0 || req > 32) ? 32 : req;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cntm = 0;
    end else begin
      int wp;
      wp = xing_i ? 0 : cntm;
      hist[tick % HN] = mdl[(wp - int'(lat_offset_i)) & (PD - 1)];
      mdl[wp] = sample_i;
      cntm = (wp + 1) % PD;
      if (l1_accept_i) begin
        acc_tick[l1_sel_i] = tick;
        acc_len[l1_sel_i]  = eff(int'(cap_len_i));
      end
      tick++;
    end
  end

  // Sample stream driver
  initial begin
    int seq = 0;
    sample_i = '0;
    forever begin
      @(negedge clk);
      sample_i = {8'(seq * 7), 32'(seq * 32'h9E3779B1)};
      seq++;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_capture(input int sel, input int len);
    l1_accept_i = 1'b1;
    l1_sel_i    = 2'(sel);
    cap_len_i   = 6'(len);
    @(negedge clk);
    l1_accept_i = 1'b0;
  endtask

  task automatic do_read(input int sel, input int exp_len, input int inject, input bit chkdata, input string req);
    int idx = 0;
    l2_accept_i = 1'b1;
    l2_sel_i    = 2'(sel);
    @(negedge clk);
    l2_accept_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after accept", W'(busy_o), W'(1));
    for (int c = 0; c < exp_len + 8; c++) begin
      if (inject == c) begin
        l2_accept_i = 1'b1;
        l2_sel_i    = 2'(sel ^ 1);
      end
      @(negedge clk);
      l2_accept_i = 1'b0;
      if (rd_valid_o) begin
        if (chkdata)
          chk(rd_data_o === hist[(acc_tick[sel] + idx) % HN], req,
              rd_data_o, hist[(acc_tick[sel] + idx) % HN]);
        chk(rd_last_o == (idx == exp_len - 1), "R9 last flag", W'(rd_last_o), W'(idx == exp_len - 1));
        idx++;
      end
    end
    chk(idx == exp_len, "R8 word count", W'(idx), W'(exp_len));
    chk(busy_o == 1'b0, "R10 busy released", W'(busy_o), W'(0));
  endtask

  task automatic test_reset;
    rst = 1'b1;
    wait_n(4);
    chk(!busy_o && !rd_valid_o && !rd_last_o, "R1 in reset", W'({busy_o, rd_valid_o, rd_last_o}), W'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !rd_valid_o && !rd_last_o, "R1 after reset", W'({busy_o, rd_valid_o, rd_last_o}), W'(0));
    xing_i = 1'b1;
    @(negedge clk);
    xing_i = 1'b0;
    wait_n(600);
  endtask

  task automatic test_default_len;
    do_read(3, 32, -1, 1'b0, "R8 never captured");
  endtask

  task automatic test_basic;
    do_capture(0, 8);
    wait_n(12);
    do_read(0, 8, -1, 1'b1, "R4 capture data");
  endtask

  task automatic test_clip;
    do_capture(1, 0);
    wait_n(36);
    do_read(1, 32, -1, 1'b1, "R5 zero length");
    do_capture(1, 40);
    wait_n(36);
    do_read(1, 32, -1, 1'b1, "R5 oversize length");
  endtask

  task automatic test_overlap;
    do_capture(2, 10);
    wait_n(2);
    do_capture(3, 5);
    wait_n(14);
    do_read(2, 10, -1, 1'b1, "R6 overlap buf2");
    do_read(3, 5, -1, 1'b1, "R6 overlap buf3");
    do_capture(0, 20);
    do_read(2, 10, -1, 1'b1, "R6 read while filling");
    do_read(0, 20, -1, 1'b1, "R6 filled during read");
    do_capture(2, 12);
    wait_n(3);
    do_capture(2, 6);
    wait_n(10);
    do_read(2, 6, -1, 1'b1, "R6 restart");
  endtask

  task automatic test_overwrite;
    do_capture(1, 16);
    wait_n(20);
    do_capture(1, 4);
    wait_n(8);
    do_read(1, 4, -1, 1'b1, "R7 overwrite unread");
  endtask

  task automatic test_offset;
    lat_offset_i = 9'd300;
    wait_n(2);
    do_capture(0, 12);
    wait_n(16);
    do_read(0, 12, -1, 1'b1, "R3 long offset");
    lat_offset_i = 9'd1;
    wait_n(2);
    do_capture(3, 7);
    wait_n(10);
    do_read(3, 7, -1, 1'b1, "R3 short offset");
  endtask

  task automatic test_marker;
    lat_offset_i = 9'd5;
    wait_n(2);
    xing_i = 1'b1;
    @(negedge clk);
    xing_i = 1'b0;
    do_capture(3, 10);
    wait_n(14);
    do_read(3, 10, -1, 1'b1, "R2 marker restart");
  endtask

  task automatic test_ignore;
    do_read(0, acc_len[0], 2, 1'b1, "R10 accept ignored");
  endtask

  initial begin
    rst = 1'b1; xing_i = 1'b0; lat_offset_i = 9'd20; cap_len_i = 6'd8;
    l1_accept_i = 1'b0; l1_sel_i = 2'd0; l2_accept_i = 1'b0; l2_sel_i = 2'd0;
    @(negedge clk);
    test_reset();
    test_default_len();
    test_basic();
    test_clip();
    test_overlap();
    test_overwrite();
    test_offset();
    test_marker();
    test_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule